// File: doc/BRIEF.md
# Multi-mode configurable logic cell

A single programmable logic cell of the kind tiled across a reconfigurable fabric. Two 3-input lookup tables share one index and are combined into either a single 4-input function (selected by input `d`), or two separate functions of the same three operands, one of which drives the carry-out. A small operand selector chooses the table index per mode. In multiplier mode the selector uses a dedicated AND of `a` and `b` as the partial product. In counter mode it feeds back the cell's own registered output. One flip-flop captures the combinational result, and a configuration bit chooses whether the pin `y` shows the flip-flop or the raw function.

The cell is configured through a 20-bit serial chain. Bits are loaded LSB first while `cfg_en` is high, and the chain's lowest bit appears on `cfg_so` so that cells can be daisy-chained. The configuration the cell actually runs on is a separate copy. It is refreshed from the chain on every clock with `cfg_en` low, so a half-shifted pattern never reaches the logic. The flip-flop also holds its value while shifting.

Top module: `logic_cell`

## Requirements
- R1: An asynchronous active-low reset clears the chain, the active configuration and the flip-flop, so after reset `y`, `cout` and `cfg_so` are 0.
- R2: The active configuration word is laid out as table bits [15:0], mode field [18:16] and output-select bit [19]. In general mode (code 0) the function equals table bit `{d,c,b,a}`, with `d` as the most significant index bit and the function's index range covering bits [15:0].
- R3: With bit [19] = 1, `y` is the combinational function. With bit [19] = 0, `y` is the flip-flop, and the flip-flop captures the function on every clock where `cfg_en` is low.
- R4: In arithmetic mode (code 1) the index is k = `{cin,b,a}`. The function is table bit k and `cout` is table bit 8+k.
- R5: In multiplier mode (code 2) the index is k = `{cin, a&b, c}`. The function is table bit k and `cout` is table bit 8+k.
- R6: In counter mode (code 3) the index is k = `{0,cin,q}`, where q is the flip-flop value. The function is table bit k and `cout` is table bit 8+k, so a table of 16'h0806 makes a toggle counter with carry.
- R7: In multiplexer mode (code 4) the function is table bit `{c,b,a}` and `d` has no effect. With table 16'h00CA the output is `a` when `c`=0 and `b` when `c`=1.
- R8: `cout` is 0 in general mode, in multiplexer mode and for the unused codes 5 to 7, which behave as general mode.
- R9: While `cfg_en` is high, each clock shifts `cfg_si` into chain bit 19 and moves every bit down one place. `cfg_so` always shows chain bit 0, so after 20 shifts the first bit sent sits at bit 0.
- R10: The active configuration is copied from the chain on each clock with `cfg_en` low and held while `cfg_en` is high. The flip-flop also holds while `cfg_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 1 | Data input / addend |
| b | input | 1 | Data input / addend |
| c | input | 1 | Data input / mux select / partial sum |
| d | input | 1 | Data input, table-half select in general mode |
| cin | input | 1 | Carry-in |
| cfg_si | input | 1 | Configuration serial data in |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_so | output | 1 | Configuration serial data out (chain bit 0) |
| y | output | 1 | Cell output, direct or registered |
| cout | output | 1 | Carry-out |

## Verification
The bench builds the cell with the package defaults: 3-input table halves, which give a 16-bit table and a 20-bit chain. Because the chain is this short, every bit pattern and every field of it is reachable by full serial loads. Within a few hundred cycles each mode can be exercised with random operands, both output selections can be covered, and reloads can be made while the previous configuration is still running. The unused mode codes and the hold behaviour during shifting also come within reach at these sizes.

// File: rtl/cell_pkg.sv
`timescale 1ns/1ps
package cell_pkg;
  localparam int LUT_IN   = 3;
  localparam int HALF_W   = 1 << LUT_IN;
  localparam int TBL_W    = 2 * HALF_W;
  localparam int MODE_W   = 3;
  localparam int CFG_W    = TBL_W + MODE_W + 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_GEN   = 3'd0,
    MODE_ARITH = 3'd1,
    MODE_MULT  = 3'd2,
    MODE_CNT   = 3'd3,
    MODE_MUX   = 3'd4
  } mode_e;

  typedef struct packed {
    logic              direct;
    logic [MODE_W-1:0] mode;
    logic [TBL_W-1:0]  tbl;
  } cfg_t;
endpackage

// File: rtl/cfg_chain.sv
`timescale 1ns/1ps
module cfg_chain #(
  parameter int CFG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             si_i,
  input  logic             en_i,
  output logic             so_o,
  output logic [CFG_W-1:0] active_o
);
  logic [CFG_W-1:0] chain_q, chain_d;
  logic [CFG_W-1:0] act_q, act_d;

  always_comb begin
    chain_d = chain_q;
    act_d   = act_q;
    if (en_i) chain_d = {si_i, chain_q[CFG_W-1:1]};
    else      act_d   = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      act_q   <= '0;
    end else begin
      chain_q <= chain_d;
      act_q   <= act_d;
    end
  end

  assign so_o     = chain_q[0];
  assign active_o = act_q;

  assert_scan_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> so_o == $past(chain_q[1]));
  assert_active_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(active_o));
  assert_active_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> active_o == $past(chain_q));
endmodule

// File: rtl/operand_sel.sv
`timescale 1ns/1ps
module operand_sel
  import cell_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              c_i,
  input  logic              cin_i,
  input  logic              q_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic pprod;
  assign pprod = a_i & b_i;

  always_comb begin
    idx_o = '0;
    unique case (mode_i)
      MODE_ARITH: begin idx_o[2] = cin_i; idx_o[1] = b_i;   idx_o[0] = a_i; end
      MODE_MULT:  begin idx_o[2] = cin_i; idx_o[1] = pprod; idx_o[0] = c_i; end
      MODE_CNT:   begin idx_o[1] = cin_i; idx_o[0] = q_i; end
      default:    begin idx_o[2] = c_i;   idx_o[1] = b_i;   idx_o[0] = a_i; end
    endcase
  end
endmodule

// File: rtl/lut_pair.sv
`timescale 1ns/1ps
module lut_pair #(
  parameter int IDX_W = 3,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic [2*DEPTH-1:0] tbl_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [1:0]         out_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DEPTH-1:0] half;
    assign half     = tbl_i[h*DEPTH +: DEPTH];
    assign out_o[h] = half[idx_i];
  end
endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
  import cell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic cin,
  input  logic cfg_si,
  input  logic cfg_en,
  output logic cfg_so,
  output logic y,
  output logic cout
);
  logic [CFG_W-1:0]  act_bits;
  cfg_t              act;
  logic [LUT_IN-1:0] idx;
  logic [1:0]        tbl_out;
  logic              fn, carry;
  logic              q_q, q_d;

  cfg_chain #(.CFG_W(CFG_W)) i_chain (
    .clk(clk), .rst_n(rst_n), .si_i(cfg_si), .en_i(cfg_en),
    .so_o(cfg_so), .active_o(act_bits)
  );
  assign act = cfg_t'(act_bits);

  operand_sel #(.IDX_W(LUT_IN)) i_sel (
    .mode_i(act.mode), .a_i(a), .b_i(b), .c_i(c), .cin_i(cin),
    .q_i(q_q), .idx_o(idx)
  );

  lut_pair #(.IDX_W(LUT_IN)) i_lut (
    .tbl_i(act.tbl), .idx_i(idx), .out_o(tbl_out)
  );

  always_comb begin
    fn    = tbl_out[0];
    carry = 1'b0;
    unique case (act.mode)
      MODE_ARITH, MODE_MULT, MODE_CNT: carry = tbl_out[1];
      MODE_MUX:                        fn    = tbl_out[0];
      default:                         fn    = d ? tbl_out[1] : tbl_out[0];
    endcase
  end

  always_comb begin
    q_d = q_q;
    if (!cfg_en) q_d = fn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign y    = act.direct ? fn : q_q;
  assign cout = carry;

  assert_ff_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> q_q == $past(fn));
  assert_ff_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(q_q));
  assert_cout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act.mode == MODE_GEN || act.mode == MODE_MUX || act.mode > MODE_MUX) |-> !cout);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!q_q && !cfg_so));
endmodule

// File: tb/test_logic_cell.sv
`timescale 1ns/1ps
module test_logic_cell;
  logic clk = 1'b0;
  logic rst_n, a, b, c, d, cin, cfg_si, cfg_en;
  logic cfg_so, y, cout;
  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;

  logic [19:0] m_chain, m_act;
  logic        m_q;

  always #2.5 clk = ~clk;

  logic_cell i_logic_cell (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d), .cin(cin),
    .cfg_si(cfg_si), .cfg_en(cfg_en), .cfg_so(cfg_so), .y(y), .cout(cout)
  );

  // returns {function, carry}
  function automatic logic [1:0] eval(input logic [19:0] cf, input logic ia, ib, ic, id, icin, iq);
    logic [15:0] t;
    int m, k;
    t = cf[15:0];
    m = int'(cf[18:16]);
    case (m)
      1: begin k = int'({icin, ib, ia});        return {t[k], t[8+k]}; end
      2: begin k = int'({icin, ia & ib, ic});   return {t[k], t[8+k]}; end
      3: begin k = int'({icin, iq});            return {t[k], t[8+k]}; end
      4: begin k = int'({ic, ib, ia});          return {t[k], 1'b0}; end
      default: begin k = int'({id, ic, ib, ia}); return {t[k], 1'b0}; end
    endcase
  endfunction

  function automatic string mode_tag(input logic [19:0] cf);
    case (int'(cf[18:16]))
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      0: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle reference model
  always @(negedge clk) begin
    logic [1:0] e;
    if (!rst_n) begin m_chain = '0; m_act = '0; m_q = 1'b0; end
    if (mon_on) begin
      e = eval(m_act, a, b, c, d, cin, m_q);
      check(m_act[19] ? mode_tag(m_act) : "R3", y, m_act[19] ? e[1] : m_q);
      check((m_act[18:16] inside {3'd1, 3'd2, 3'd3}) ? mode_tag(m_act) : "R8", cout, e[0]);
      check("R9", cfg_so, m_chain[0]);
      if (rst_n) begin
        if (cfg_en) m_chain = {cfg_si, m_chain[19:1]};
        else begin m_act = m_chain; m_q = e[1]; end
      end
    end
  end

  task automatic rand_ops();
    a = 1'($urandom); b = 1'($urandom); c = 1'($urandom);
    d = 1'($urandom); cin = 1'($urandom);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; cfg_en = 1'b0; rand_ops();
    end
  endtask

  task automatic load(input logic [19:0] w);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; cfg_en = 1'b1; cfg_si = w[i]; rand_ops();
    end
    @(posedge clk); #1; cfg_en = 1'b0; rand_ops();
    @(posedge clk); #1; rand_ops();
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_si = 1'b0;
    a = 0; b = 0; c = 0; d = 0; cin = 0;
    repeat (3) @(posedge clk);
    mon_on = 1;
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", y, 1'b0); check("R1", cout, 1'b0); check("R1", cfg_so, 1'b0);

    // general mode, direct and registered
    load({1'b1, 3'd0, 16'hB38E}); run(60);
    load({1'b0, 3'd0, 16'h6A51}); run(60);
    // arithmetic full adder
    load({1'b1, 3'd1, 16'hE896}); run(60);
    @(posedge clk); #1; a = 1; b = 1; cin = 1;
    @(negedge clk); #1; check("R4", y, 1'b1); check("R4", cout, 1'b1);
    load({1'b0, 3'd1, 16'hE896}); run(40);
    // multiplier cell
    load({1'b1, 3'd2, 16'hE896}); run(60);
    @(posedge clk); #1; a = 1; b = 1; c = 1; cin = 0;
    @(negedge clk); #1; check("R5", y, 1'b0); check("R5", cout, 1'b1);
    // mux, d ignored
    load({1'b1, 3'd4, 16'h35CA}); run(60);
    @(posedge clk); #1; a = 1; b = 0; c = 0; d = 0;
    @(negedge clk); #1; check("R7", y, 1'b1);
    @(posedge clk); #1; d = 1;
    @(negedge clk); #1; check("R7", y, 1'b1); check("R8", cout, 1'b0);
    @(posedge clk); #1; c = 1;
    @(negedge clk); #1; check("R7", y, 1'b0);
    // counter toggles with cin=1
    load({1'b0, 3'd3, 16'h0806}); run(30);
    begin
      logic prev;
      @(posedge clk); #1; cin = 1;
      @(negedge clk); #1; prev = y;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1; check("R6", y, ~prev); prev = y;
      end
      // hold while shifting: flip-flop frozen
      @(posedge clk); #1; cfg_en = 1; cfg_si = 1;
      @(negedge clk); #1; prev = y;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #1; check("R10", y, prev);
      end
    end
    // reserved codes behave as general
    load({1'b1, 3'd6, 16'hF00F}); run(40);
    load({1'b1, 3'd7, 16'h1234}); run(40);
    // old config keeps running during a reload
    load({1'b1, 3'd4, 16'h00CA});
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; cfg_en = 1; cfg_si = 1'($urandom);
      a = 1; b = 0; c = 0;
      @(negedge clk); #1; check("R10", y, 1'b1);
    end
    run(40);
    // mid-run reset
    @(posedge clk); #1; rst_n = 0;
    @(negedge clk); #1; check("R1", y, 1'b0); check("R1", cfg_so, 1'b0);
    @(posedge clk); #1; rst_n = 1;
    run(10);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule